// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is a synchronous controller for a dispenser with one coin slot. The slot takes nickels and dimes. Each accepted coin arrives as a one-cycle pulse, already synchronized to the clock. The controller tracks the credit in four levels: nothing, five, ten and fifteen cents. When the credit reaches the fifteen-cent price it raises a single vend signal. It never returns change. Any overpayment is simply absorbed into the fifteen-cent level. After a vend, the credit starts again from zero, so each fifteen cents buys one item.

A parameter picks how the vend signal is formed, and each choice gives different cycle-level timing:

- **State-based form.** The signal depends only on the stored credit, so it rises one cycle after the coin that completes the price.
- **Transition-based form.** The signal is decoded from the stored credit together with the incoming coin, so it rises in the same cycle as that final coin.
- **Latched transition form.** The transition-based value passes through a clocked holding register. The signal is therefore glitch-free and stable for a whole cycle, one cycle after the decision.

Top module: `vend_ctrl`

## Requirements
- R1: A lone nickel pulse adds 5 cents and a lone dime pulse adds 10 cents to the credit. With no coin pulse, the credit holds at 0, 5 or 10 cents.
- R2: Any single coin that brings the credit to 15 cents or more moves the controller to the 15-cent level. A dime at 10 cents therefore also lands at 15, and no change is computed.
- R3: Nickel and dime pulses in the same cycle count as no coin. The credit holds, and the transition-based vend signal stays 0 for that cycle.
- R4: The reset is synchronous and active-high. It returns the credit to 0 from any level, and it takes priority over coin pulses in the same cycle.
- R5: The 15-cent level lasts exactly one cycle. On the next cycle without reset, the credit restarts from 0, and any coin pulse in that 15-cent cycle is added to the fresh 0.
- R6: With OUT_STYLE = 0 (state-based), the vend signal is 1 exactly while the stored credit is 15 cents, whatever the inputs are. It rises one cycle after the final coin.
- R7: With OUT_STYLE = 1 (transition-based), the vend signal is combinational. It is 1 when reset is low and either the credit is 10 cents with a lone nickel or a lone dime, or the credit is 5 cents with a lone dime. It is also 1 when the credit is 15 cents with reset high. It is 0 in every other case, so it rises in the same cycle as the final coin.
- R8: With OUT_STYLE = 2 (latched transition form), the vend signal equals the OUT_STYLE = 1 value of the previous cycle. A cycle with reset high clears it to 0 for the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| coin_nickel | input | 1 | One-cycle pulse: a nickel was accepted |
| coin_dime | input | 1 | One-cycle pulse: a dime was accepted |
| vend_open | output | 1 | Release one item |

## Verification
The bench builds three copies of the block with OUT_STYLE set to 0, 1 and 2, and drives all three from the same coin and reset sequence. Because they share stimulus, the bench can show the timing relation between the forms directly: the transition-based copy rises in the cycle of the final coin, the state-based copy rises one cycle later, and the latched copy mirrors the transition decision one cycle late. The directed cases cover overpayment, double-coin cycles, reset during each credit level and coins arriving during the vend cycle. A long seeded random run then covers the remaining combinations.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int unsigned CREDIT_W       = 2;
    localparam int unsigned STEP_SUM_W     = CREDIT_W + 1;
    localparam int unsigned PRICE_STEPS    = 3;
    localparam int unsigned NICKEL_STEPS   = 1;
    localparam int unsigned DIME_STEPS     = 2;

    localparam int unsigned STYLE_MOORE     = 0;
    localparam int unsigned STYLE_MEALY     = 1;
    localparam int unsigned STYLE_MEALY_REG = 2;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'd0,
        CR_5  = 2'd1,
        CR_10 = 2'd2,
        CR_15 = 2'd3
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2,
        COIN_BOTH   = 2'd3
    } coin_e;

    typedef struct packed {
        credit_e cur;
        coin_e   coin;
    } step_in_t;

    function automatic coin_e classify_coin(input logic nickel, input logic dime);
        coin_e c;
        case ({dime, nickel})
            2'b01:   c = COIN_NICKEL;
            2'b10:   c = COIN_DIME;
            2'b11:   c = COIN_BOTH;
            default: c = COIN_NONE;
        endcase
        return c;
    endfunction

    function automatic logic [STEP_SUM_W-1:0] coin_steps(input coin_e c);
        logic [STEP_SUM_W-1:0] s;
        case (c)
            COIN_NICKEL: s = STEP_SUM_W'(NICKEL_STEPS);
            COIN_DIME:   s = STEP_SUM_W'(DIME_STEPS);
            default:     s = '0;
        endcase
        return s;
    endfunction

    function automatic credit_e restart_base(input credit_e cur);
        return (cur == CR_15) ? CR_0 : cur;
    endfunction

    function automatic credit_e add_credit(input step_in_t si);
        logic [STEP_SUM_W-1:0] sum;
        credit_e base;
        base = restart_base(si.cur);
        sum  = {1'b0, base} + coin_steps(si.coin);
        if (sum >= STEP_SUM_W'(PRICE_STEPS)) begin
            return CR_15;
        end
        return credit_e'(sum[CREDIT_W-1:0]);
    endfunction

    function automatic logic reaches_price(input step_in_t si);
        return (si.cur != CR_15) && (coin_steps(si.coin) != '0)
               && (add_credit(si) == CR_15);
    endfunction

endpackage

// File: rtl/vend_coin_sense.sv
module vend_coin_sense
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);
    always_comb begin
        coin_o = classify_coin(nickel_i, dime_i);
    end
endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm
    import vend_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  coin_e   coin_i,
    output credit_e credit_o
);
    credit_e  credit_q;
    credit_e  credit_d;
    step_in_t step;

    always_comb begin
        step.cur  = credit_q;
        step.coin = coin_i;
        credit_d  = add_credit(step);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= CR_0;
        end else begin
            credit_q <= credit_d;
        end
    end

    assign credit_o = credit_q;

    // R4: reset lands on zero credit whatever the coins were
    assert_reset_clears_R4: assert property (@(posedge clk)
        rst |=> credit_q == CR_0);

    // R5: the vend level never lasts two cycles
    assert_vend_level_once_R5: assert property (@(posedge clk) disable iff (rst)
        credit_q == CR_15 |=> credit_q != CR_15);

    // R3: a double-coin cycle leaves the credit unchanged below the price
    assert_double_coin_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (coin_i == COIN_BOTH && credit_q != CR_15) |=> $stable(credit_q));

    // R1: a nickel from empty gives five cents
    assert_nickel_from_empty_R1: assert property (@(posedge clk) disable iff (rst)
        (coin_i == COIN_NICKEL && credit_q == CR_0) |=> credit_q == CR_5);

    // R2: a dime at ten cents is absorbed into the vend level
    assert_overpay_saturates_R2: assert property (@(posedge clk) disable iff (rst)
        (coin_i == COIN_DIME && credit_q == CR_10) |=> credit_q == CR_15);
endmodule

// File: rtl/vend_open_gen.sv
module vend_open_gen
    import vend_pkg::*;
#(
    parameter int unsigned OUT_STYLE = STYLE_MEALY
) (
    input  logic    clk,
    input  logic    rst,
    input  credit_e credit_i,
    input  coin_e   coin_i,
    output logic    open_o
);
    step_in_t step;
    logic     arrow_open;

    always_comb begin
        step.cur  = credit_i;
        step.coin = coin_i;
        if (rst) begin
            arrow_open = (credit_i == CR_15);
        end else begin
            arrow_open = reaches_price(step);
        end
    end

    generate
        if (OUT_STYLE == STYLE_MOORE) begin : g_moore
            assign open_o = (credit_i == CR_15);

            // R6: the state-based vend pulse is one cycle wide
            assert_single_cycle_vend_R6: assert property (@(posedge clk) disable iff (rst)
                open_o |=> !open_o);
        end else if (OUT_STYLE == STYLE_MEALY) begin : g_mealy
            assign open_o = arrow_open;

            // R7: a transition vend always leads into the vend level
            assert_mealy_leads_state_R7: assert property (@(posedge clk) disable iff (rst)
                open_o |=> credit_i == CR_15);
            // R3: the double-coin input never vends
            assert_double_coin_no_vend_R3: assert property (@(posedge clk) disable iff (rst)
                coin_i == COIN_BOTH |-> !open_o);
        end else begin : g_mealy_reg
            logic open_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q <= 1'b0;
                end else begin
                    open_q <= arrow_open;
                end
            end
            assign open_o = open_q;

            // R8: the held vend coincides with the vend level
            assert_latched_with_level_R8: assert property (@(posedge clk) disable iff (rst)
                open_o |-> credit_i == CR_15);
            // R8: the held vend is one cycle wide
            assert_latched_single_R8: assert property (@(posedge clk) disable iff (rst)
                open_o |=> !open_o);
        end
    endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int unsigned OUT_STYLE = STYLE_MEALY
) (
    input  logic clk,
    input  logic rst,
    input  logic coin_nickel,
    input  logic coin_dime,
    output logic vend_open
);
    coin_e   coin;
    credit_e credit;

    initial begin
        assert (OUT_STYLE <= STYLE_MEALY_REG)
            else $error("OUT_STYLE out of range");
    end

    vend_coin_sense u_sense (
        .nickel_i (coin_nickel),
        .dime_i   (coin_dime),
        .coin_o   (coin)
    );

    vend_credit_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .coin_i   (coin),
        .credit_o (credit)
    );

    vend_open_gen #(
        .OUT_STYLE (OUT_STYLE)
    ) u_open (
        .clk      (clk),
        .rst      (rst),
        .credit_i (credit),
        .coin_i   (coin),
        .open_o   (vend_open)
    );
endmodule

// File: tb/tb_vend_ctrl.sv
`timescale 1ns/1ps
module tb_vend_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nk  = 1'b0;
    logic dm  = 1'b0;
    logic open_moore, open_mealy, open_reg;

    always #2.5 clk = ~clk;

    vend_ctrl #(.OUT_STYLE(0)) dut_moore (.clk(clk), .rst(rst), .coin_nickel(nk), .coin_dime(dm), .vend_open(open_moore));
    vend_ctrl #(.OUT_STYLE(1)) dut       (.clk(clk), .rst(rst), .coin_nickel(nk), .coin_dime(dm), .vend_open(open_mealy));
    vend_ctrl #(.OUT_STYLE(2)) dut_reg   (.clk(clk), .rst(rst), .coin_nickel(nk), .coin_dime(dm), .vend_open(open_reg));

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cr       = 0;
    bit  exp_reg  = 1'b0;
    bit  valid    = 1'b0;
    bit  done     = 1'b0;

    function automatic int coin_add(bit n, bit d);
        if (n && !d) return 5;
        if (d && !n) return 10;
        return 0;
    endfunction

    function automatic int next_cr(int c, bit n, bit d, bit r);
        int s;
        if (r) return 0;
        s = ((c == 15) ? 0 : c) + coin_add(n, d);
        return (s >= 15) ? 15 : s;
    endfunction

    function automatic bit mealy_exp(int c, bit n, bit d, bit r);
        if (r) return (c == 15);
        return (c != 15) && (coin_add(n, d) != 0) && (c + coin_add(n, d) >= 15);
    endfunction

    function automatic string scene(int c, bit n, bit d, bit r);
        if (r) return "R4";
        if (n && d) return "R3";
        if (c == 15) return "R5";
        if (coin_add(n, d) != 0 && c + coin_add(n, d) >= 15) return "R2";
        return "R1";
    endfunction

    task automatic check(string tag, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s credit=%0d actual=%b expected=%b", tag, cr, act, exp);
        end
    endtask

    task automatic step(bit n, bit d, bit r);
        bit em;
        string sc;
        @(negedge clk);
        nk = n; dm = d; rst = r;
        #1;
        sc = scene(cr, n, d, r);
        em = mealy_exp(cr, n, d, r);
        if (valid) begin
            check({"R6/", sc}, open_moore, cr == 15);
            check({"R7/", sc}, open_mealy, em);
            check({"R8/", sc}, open_reg, exp_reg);
        end
        exp_reg = r ? 1'b0 : em;
        cr      = next_cr(cr, n, d, r);
        valid   = 1'b1;
    endtask

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired after %0d cycles expected finish", cyc);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd2718));
        step(0, 0, 1);
        step(0, 0, 1);
        // reset state R4 after reset: all outputs low
        step(0, 0, 0);
        // three nickels R1 R2: mealy on third coin, moore a cycle later
        step(1, 0, 0); step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
        // dime then nickel, nickel then dime
        step(0, 1, 0); step(1, 0, 0); step(0, 0, 0);
        step(1, 0, 0); step(0, 1, 0); step(0, 0, 0);
        // overpay R2: two dimes
        step(0, 1, 0); step(0, 1, 0); step(0, 0, 0);
        // double coin R3 at 0, 5 and 10
        step(1, 1, 0); step(1, 0, 0); step(1, 1, 0); step(1, 0, 0); step(1, 1, 0); step(1, 1, 0);
        step(0, 1, 0); step(0, 0, 0);
        // reset dominates coins at 10 R4
        step(0, 1, 0); step(0, 1, 1); step(0, 0, 0);
        // reset while at 15 R4/R7
        step(0, 1, 0); step(1, 0, 0); step(0, 0, 1); step(0, 0, 0);
        // coin during the vend cycle R5
        step(0, 1, 0); step(0, 1, 0); step(0, 1, 0); step(1, 0, 0); step(0, 0, 0);
        step(1, 0, 0); step(0, 1, 0); step(1, 0, 0); step(1, 0, 0); step(0, 0, 0);
        // seeded random run
        for (int i = 0; i < 4000; i++) begin
            int unsigned v;
            v = $urandom;
            step(v[0], v[1], v[5:2] == 4'd0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule